// File: doc/BRIEF.md
# Flash Program/Erase Control and Status Register

This block is the processor-visible byte that supervises an embedded flash program/erase engine. Software uses it to arm program/erase operations, to choose the flash access-timing setting, and to learn when an operation has finished, either by polling or through an interrupt. A flash operation sequencer supplies a start request and end-of-operation pulses. The block returns a gated program/erase strobe, an interrupt request and the stored timing field.

The byte holds the following fields:

| Bit | Field | Access |
|-----|-------|--------|
| 7 | interrupt enable | read/write |
| 6 | completion flag | clear by writing 0 |
| 5 | program/erase enable | read/write |
| 4 | ready status | read-only |
| 3, 1 | reserved | read as 1 |
| 2, 0 | access-timing field | read/write; bit 2 is the high bit |

The ready bit and the completion flag are updated on different clock cycles. The ready bit moves first, so software may poll either one. A read flagged as the read half of a read-modify-write returns 1 in the flag position. Because of this, the write-back that follows cannot clear a completion by accident.

Top module: `flash_ctl_reg`

## Requirements
- R1: After a synchronous active-low reset, a read returns 0x1A (interrupt enable 0, flag 0, enable 0, ready 1, reserved 1, timing 00). In that state `irq` and `pe_strobe` are 0 and `acc_timing` is 00.
- R2: `irq` is 1 exactly when bit 7 and bit 6 are both 1. With bit 7 at 0, `irq` stays 0 even when the flag is set.
- R3: An end pulse on `op_done` or `algo_done` in cycle t sets ready (bit 4) after the edge ending cycle t. It sets the flag (bit 6) one edge later, so the two bits never rise on the same edge for a single operation.
- R4: A write with bit 6 = 0 clears the flag. A write with bit 6 = 1 leaves the flag unchanged. If a hardware set of the flag and a clearing write fall on the same edge, the flag ends up 1.
- R5: A read with `bus_rmw` = 1 returns 1 in bit 6 whatever the flag holds. A plain read returns the real flag.
- R6: Bit 5 resets to 0. `pe_strobe` is 1 in the same cycle as `seq_start` only when bit 5 and ready are both 1. Otherwise no strobe is passed.
- R7: A passed strobe clears ready on the next edge. A start request while ready is 0 gives no strobe. Bus writes never change ready.
- R8: Bits 3 and 1 always read 1 and ignore writes. Bits 2 and 0 are stored on a write and drive `acc_timing[1]` and `acc_timing[0]`. `bus_rdata` is 0 whenever `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_rmw | input | 1 | Marks the read as the read half of a read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| seq_start | input | 1 | Program/erase start request from the command sequence |
| op_done | input | 1 | Program/erase operation ended (pulse) |
| algo_done | input | 1 | Automatic flash algorithm ended (pulse) |
| pe_strobe | output | 1 | Gated program/erase strobe to the flash |
| irq | output | 1 | Interrupt request to the processor |
| acc_timing | output | 2 | Access-timing setting to the flash interface |

## Verification
A stale or wrong ready bit shows up in the same cycle at `pe_strobe`: a start is wrongly passed or wrongly blocked. A wrong enable bit shows up in the same way. A flag that is set too early, set too late or lost to a clearing write shows on `irq` as soon as the interrupt enable is 1. It also shows on the next plain read, one edge off from the expected position. Because the reference model is compared every cycle under both directed and mixed stimulus, a single-cycle misplacement of any field is caught within a cycle of the first read or strobe that exposes it.

// File: rtl/fcr_pkg.sv
// Shared constants for the flash control/status register: field positions
// and the reset image. Positions matter because software decodes them.
package fcr_pkg;
    localparam int REG_W  = 8;
    localparam int TIM_W  = 2;
    localparam int RSV_N  = 2;
    localparam int B_IE   = 7;
    localparam int B_FLAG = 6;
    localparam int B_EN   = 5;
    localparam int B_RDY  = 4;
    // Timing field bit i sits at register bit TIM_POS[i].
    localparam int TIM_POS [TIM_W] = '{0, 2};
    // Reserved bits that always read 1.
    localparam int RSV_POS [RSV_N] = '{1, 3};
    localparam logic [REG_W-1:0] RST_IMG = 8'h1A;
endpackage

// File: rtl/fcr_ctrl.sv
// Software-owned control fields: interrupt enable, program/erase enable
// and the access-timing field.
// Assumes: wr_en is a single-cycle strobe qualified by the bus.
module fcr_ctrl
    import fcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic             ie_q,
    output logic             en_q,
    output logic [TIM_W-1:0] tim_q
);
    // Load the writable control fields from the bus, or the reset image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= RST_IMG[B_IE];
            en_q <= RST_IMG[B_EN];
            for (int i = 0; i < TIM_W; i++) tim_q[i] <= RST_IMG[TIM_POS[i]];
        end else if (wr_en) begin
            ie_q <= wdata[B_IE];
            en_q <= wdata[B_EN];
            for (int i = 0; i < TIM_W; i++) tim_q[i] <= wdata[TIM_POS[i]];
        end
    end
endmodule

// File: rtl/fcr_status.sv
// Hardware-owned status: ready bit, completion flag and strobe gating.
// Ready moves on the edge after an end pulse. The flag follows one edge later
// through a pending register. A hardware flag set beats a clearing write.
// Assumes: end pulses arrive only from the sequencer; a strobe outranks
// a coincident end pulse for the ready bit.
module fcr_status
    import fcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic en_q,
    input  logic end_op,
    input  logic end_algo,
    input  logic wr_en,
    input  logic wr_flag,
    output logic rdy_q,
    output logic flag_q,
    output logic pend_q,
    output logic strobe
);
    logic end_any;

    // Pass a start only when enabled and idle; merge both end sources.
    always_comb begin
        strobe  = start_req & en_q & rdy_q;
        end_any = end_op | end_algo;
    end

    // Ready: cleared by a passed strobe, set by an end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdy_q <= RST_IMG[B_RDY];
        else if (strobe)  rdy_q <= 1'b0;
        else if (end_any) rdy_q <= 1'b1;
    end

    // Pending: delays the flag set by one edge behind ready.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= end_any;
    end

    // Flag: hardware set wins; a written zero clears; a written one is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= RST_IMG[B_FLAG];
        else if (pend_q)            flag_q <= 1'b1;
        else if (wr_en && !wr_flag) flag_q <= 1'b0;
    end
endmodule

// File: rtl/fcr_rdmux.sv
// Builds the read image of the register. During a read-modify-write read
// the flag position is forced to 1. Output is 0 outside a read.
module fcr_rdmux
    import fcr_pkg::*;
(
    input  logic             rd,
    input  logic             rmw,
    input  logic             ie_q,
    input  logic             flag_q,
    input  logic             en_q,
    input  logic             rdy_q,
    input  logic [TIM_W-1:0] tim_q,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] img;

    // Place every field at its bit position and gate by the read strobe.
    always_comb begin
        img         = '0;
        img[B_IE]   = ie_q;
        img[B_FLAG] = flag_q | rmw;
        img[B_EN]   = en_q;
        img[B_RDY]  = rdy_q;
        for (int i = 0; i < RSV_N; i++) img[RSV_POS[i]] = 1'b1;
        for (int i = 0; i < TIM_W; i++) img[TIM_POS[i]] = tim_q[i];
        rdata = rd ? img : '0;
    end
endmodule

// File: rtl/flash_ctl_reg.sv
// Top level of the flash control/status register. Joins the control
// fields, the status logic and the read mux, and forms the interrupt.
// Assumes: a single bus master and a synchronous active-low reset.
module flash_ctl_reg
    import fcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_rmw,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             seq_start,
    input  logic             op_done,
    input  logic             algo_done,
    output logic             pe_strobe,
    output logic             irq,
    output logic [TIM_W-1:0] acc_timing
);
    logic ie_q, en_q, rdy_q, flag_q, pend_q;
    logic [TIM_W-1:0] tim_q;

    fcr_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .wdata (bus_wdata),
        .ie_q  (ie_q),
        .en_q  (en_q),
        .tim_q (tim_q)
    );

    fcr_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (seq_start),
        .en_q      (en_q),
        .end_op    (op_done),
        .end_algo  (algo_done),
        .wr_en     (bus_wr),
        .wr_flag   (bus_wdata[B_FLAG]),
        .rdy_q     (rdy_q),
        .flag_q    (flag_q),
        .pend_q    (pend_q),
        .strobe    (pe_strobe)
    );

    fcr_rdmux u_rd (
        .rd     (bus_rd),
        .rmw    (bus_rmw),
        .ie_q   (ie_q),
        .flag_q (flag_q),
        .en_q   (en_q),
        .rdy_q  (rdy_q),
        .tim_q  (tim_q),
        .rdata  (bus_rdata)
    );

    // Interrupt request and timing output.
    always_comb begin
        irq        = ie_q & flag_q;
        acc_timing = tim_q;
    end
endmodule

// File: rtl/fcr_checker.sv
// Property checker for flash_ctl_reg, attached by bind below.
module fcr_checker
    import fcr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             bus_rmw,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic             op_done,
    input logic             algo_done,
    input logic             pe_strobe,
    input logic             irq,
    input logic             rdy_q,
    input logic             flag_q,
    input logic             en_q,
    input logic             pend_q
);
    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (rdy_q && !flag_q && !en_q)); // R1
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && !bus_rmw && !bus_rdata[B_IE]) |-> !irq); // R2
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> flag_q); // R2
    AST_READY_FIRST: assert property (@(posedge clk) disable iff (!rst_n) ((op_done || algo_done) && !pe_strobe) |=> rdy_q); // R3
    AST_FLAG_LATER: assert property (@(posedge clk) disable iff (!rst_n) (op_done || algo_done) |-> ##2 flag_q); // R3
    AST_W1_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_wdata[B_FLAG] && !flag_q && !pend_q) |=> !flag_q); // R4
    AST_RMW_ONE: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && bus_rmw) |-> bus_rdata[B_FLAG]); // R5
    AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n) pe_strobe |-> (en_q && rdy_q)); // R6
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) pe_strobe |=> !rdy_q); // R7
    AST_RSV_ONES: assert property (@(posedge clk) disable iff (!rst_n) bus_rd |-> (bus_rdata[RSV_POS[0]] && bus_rdata[RSV_POS[1]])); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |-> (bus_rdata == '0)); // R8
endmodule

bind flash_ctl_reg fcr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rmw   (bus_rmw),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .op_done   (op_done),
    .algo_done (algo_done),
    .pe_strobe (pe_strobe),
    .irq       (irq),
    .rdy_q     (rdy_q),
    .flag_q    (flag_q),
    .en_q      (en_q),
    .pend_q    (pend_q)
);

// File: tb/tb_flash_ctl_reg.sv
`timescale 1ns/1ps
module tb_flash_ctl_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       seq_start = 1'b0, op_done = 1'b0, algo_done = 1'b0;
    logic       pe_strobe, irq;
    logic [1:0] acc_timing;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Behavioural reference state.
    bit m_ie, m_flag, m_en, m_rdy, m_pend;
    bit [1:0] m_tim;

    always #10 clk = ~clk;

    flash_ctl_reg dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rmw(bus_rmw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_start(seq_start), .op_done(op_done), .algo_done(algo_done),
        .pe_strobe(pe_strobe), .irq(irq), .acc_timing(acc_timing)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare outputs mid-cycle, then advance the model across the edge.
    task automatic step(input string req);
        bit [7:0] e_rd;
        bit e_str, n_rdy, n_flag;
        #5;
        e_str = seq_start && m_en && m_rdy;
        e_rd  = bus_rd ? {m_ie, (bus_rmw ? 1'b1 : m_flag), m_en, m_rdy, 1'b1, m_tim[1], 1'b1, m_tim[0]} : 8'h00;
        if (rst_n) begin
            chk(req, "rdata", bus_rdata, e_rd);
            chk(req, "irq", irq, m_ie && m_flag);
            chk(req, "strobe", pe_strobe, e_str);
            chk(req, "timing", acc_timing, m_tim);
        end
        n_rdy  = e_str ? 1'b0 : ((op_done || algo_done) ? 1'b1 : m_rdy);
        n_flag = m_pend ? 1'b1 : ((bus_wr && !bus_wdata[6]) ? 1'b0 : m_flag);
        @(posedge clk);
        if (!rst_n) begin
            m_ie = 0; m_flag = 0; m_en = 0; m_rdy = 1; m_pend = 0; m_tim = 0;
        end else begin
            m_pend = op_done || algo_done;
            m_rdy  = n_rdy;
            m_flag = n_flag;
            if (bus_wr) begin
                m_ie = bus_wdata[7]; m_en = bus_wdata[5];
                m_tim = {bus_wdata[2], bus_wdata[0]};
            end
        end
        @(negedge clk);
    endtask

    task automatic cy(input bit wr, input bit rd, input bit rmw, input bit [7:0] wd,
                      input bit st, input bit od, input bit ad, input string req);
        bus_wr = wr; bus_rd = rd; bus_rmw = rmw; bus_wdata = wd;
        seq_start = st; op_done = od; algo_done = ad;
        step(req);
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) cy(0, 0, 0, 8'h00, 0, 0, 0, "R1");
        rst_n = 1'b1;
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R1");
        chk("R1", "reset image", m_ie | m_flag | m_en, 0);
        // Start with enable 0: no strobe.
        cy(0, 0, 0, 8'h00, 1, 0, 0, "R6");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R6");
        // Enable, start, then start again while busy.
        cy(1, 0, 0, 8'h20, 0, 0, 0, "R6");
        cy(0, 0, 0, 8'h00, 1, 0, 0, "R6");
        cy(0, 1, 0, 8'h00, 1, 0, 0, "R7");
        cy(1, 1, 0, 8'h30, 0, 0, 0, "R7");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R7");
        // End pulse: ready first, flag one edge later.
        cy(0, 1, 0, 8'h00, 0, 1, 0, "R3");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R3");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R3");
        // Interrupt gating.
        cy(1, 0, 0, 8'hE0, 0, 0, 0, "R2");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R2");
        cy(1, 0, 0, 8'h60, 0, 0, 0, "R2");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R2");
        // Write one keeps the flag, write zero clears it, rmw reads one.
        cy(1, 0, 0, 8'hE0, 0, 0, 0, "R4");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R4");
        cy(1, 0, 0, 8'hA0, 0, 0, 0, "R4");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R4");
        cy(0, 1, 1, 8'h00, 0, 0, 0, "R5");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R5");
        // Hardware set beats a clearing write on the same edge.
        cy(0, 0, 0, 8'h00, 0, 0, 1, "R3");
        cy(1, 0, 0, 8'hA0, 0, 0, 0, "R4");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R4");
        // Timing field and reserved bits.
        cy(1, 0, 0, 8'h04, 0, 0, 0, "R8");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R8");
        cy(1, 0, 0, 8'h01, 0, 0, 0, "R8");
        cy(0, 1, 0, 8'h00, 0, 0, 0, "R8");
        cy(1, 0, 0, 8'hF5, 0, 0, 0, "R8");
        cy(0, 0, 0, 8'h00, 0, 0, 0, "R8");
        // Mixed stimulus.
        for (int i = 0; i < 4000; i++) begin
            bit [7:0] r;
            r = 8'($urandom);
            cy(r[0] & r[1], r[2], r[3] & r[2], 8'($urandom), r[4],
               r[5] & r[6] & r[7], (r[5:0] == 6'd7), "R2 R3 R4 R6 R7");
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule